// File: doc/BRIEF.md
# Road Flag Tree Readout Encoder

This block drains a two-dimensional array of road flags, one flag per stored pattern, and reports the address of every flag that is set. The array is organised as columns of rows. Each column has a binary tree of selection nodes over its rows. At every node the tree works out whether any flag is set below it, and it steers toward the child with the lower index. The left/right choices made on the way down form the row number. A second tree of the same kind runs over the per-column "anything set" outputs and picks the column. The reported address is the column number followed by the row number. Each stage costs log2 of its width in node levels.

A whole flag array is taken in on a load strobe, but only while the encoder holds no flags. After that the block issues one address per clock, marks it with a valid pulse, and clears that flag in the same edge. It repeats until the array is empty, and then it raises done. Every issued address is also written into a small first-in first-out queue, so a consumer can pop the addresses later. When the queue is full the encoder pauses and loses nothing.

Top module: `rfr_road_readout`

## Requirements
- R1: After synchronous reset, out_valid is 0, done is 1 and q_empty is 1.
- R2: A load pulse is accepted only while done is 1. It replaces the held array with load_flags, where bit index c*ROWS+r is row r of column c. A load pulse while flags remain has no effect on the addresses reported.
- R3: Addresses come out in ascending column order, and within a column in ascending row order. out_addr carries the column in its upper $clog2(COLS) bits and the row in its lower $clog2(ROWS) bits.
- R4: While the queue has room, one address is reported on each clock. The first address appears on the second clock edge after the accepted load, and the rest follow on consecutive edges.
- R5: Every set flag is reported exactly once. A reported flag is cleared, and no flag appears other than by a load.
- R6: done is 0 while any flag remains. It rises in the same cycle as the out_valid of the last address. An empty load leaves done at 1.
- R7: Each reported address is also pushed into the queue. q_data shows the oldest queued address, and q_pop with q_empty low removes it.
- R8: While the queue is full, no address is issued and out_valid stays 0. Encoding resumes after a pop, and no flag is lost.
- R9: q_pop while the queue is empty has no effect. q_empty stays 1 and later data are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture strobe for load_flags, honoured only while done |
| load_flags | input | ROWS*COLS | Flag array, bit c*ROWS+r is row r of column c |
| out_valid | output | 1 | out_addr holds a newly reported address |
| out_addr | output | $clog2(COLS)+$clog2(ROWS) | Reported address {column, row} |
| done | output | 1 | No flag remains |
| q_pop | input | 1 | Remove the oldest queued address |
| q_data | output | $clog2(COLS)+$clog2(ROWS) | Oldest queued address |
| q_empty | output | 1 | Queue holds nothing |
| q_full | output | 1 | Queue holds QDEPTH addresses |

## Verification
The assertions assume that ROWS, COLS and QDEPTH are powers of two no smaller than 2. They also assume that load and q_pop are plain synchronous levels sampled at the rising edge. The bench drives every input at the falling edge, so each is stable across the sampling edge. It pulses load both while the encoder is idle and while it is draining, and it keeps q_pop either held high or held low for long stretches, so that the queue fills and stalls the encoder. Random flag densities are mixed with all-zero, all-one, single-flag and last-position arrays.

// File: rtl/rfr_pkg.sv
// Package rfr_pkg
// Shared helper for the road flag readout block.
// Assumes: callers pass widths of at least 2.
package rfr_pkg;
    // Number of tree levels needed to select among n inputs.
    function automatic int tree_levels(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/rfr_prio_tree.sv
// Module rfr_prio_tree
// Combinational binary selection tree. Every node reports whether any
// request below it is set, and it steers to its lower-index child when
// that child is active. The branch taken at each level becomes one bit of
// the index, so the selected position is built level by level.
// Assumes: N >= 2. Unused leaves of the padded tree are tied inactive.
module rfr_prio_tree #(
    parameter int N = 8
) (
    input  logic [N-1:0]                       req,
    output logic                               any,
    output logic [rfr_pkg::tree_levels(N)-1:0] idx
);
    localparam int IW = rfr_pkg::tree_levels(N);
    localparam int P  = 2 ** IW;

    // Heap-numbered nodes: 1 is the root, P..2P-1 are leaves.
    logic [2*P-1:1]         any_n;
    logic [2*P-1:1][IW-1:0] idx_n;

    generate
        // Leaf stage: real requests, padding held low.
        for (genvar k = 0; k < P; k++) begin : g_leaf
            if (k < N) begin : g_real
                assign any_n[P+k] = req[k];
            end else begin : g_pad
                assign any_n[P+k] = 1'b0;
            end
            assign idx_n[P+k] = '0;
        end
        // Inner stages: one selection node per pair of children.
        for (genvar d = 0; d < IW; d++) begin : g_lvl
            for (genvar k = 0; k < 2 ** d; k++) begin : g_node
                localparam int I = (2 ** d) + k;
                localparam int H = IW - d;
                assign any_n[I] = any_n[2*I] | any_n[2*I+1];
                assign idx_n[I] = any_n[2*I] ? idx_n[2*I]
                                             : (idx_n[2*I+1] | IW'(1 << (H - 1)));
            end
        end
    endgenerate

    assign any = any_n[1];
    assign idx = idx_n[1];
endmodule

// File: rtl/rfr_flag_bank.sv
// Module rfr_flag_bank
// Holds the flag array. It takes a whole new array on load_en and clears
// the single flag named by (clr_col, clr_row) on clr_en.
// Assumes: load_en and clr_en are never high together (the top only loads
// when no flags remain and only clears when one does).
module rfr_flag_bank #(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    localparam int NF = ROWS * COLS,
    localparam int RW = rfr_pkg::tree_levels(ROWS),
    localparam int CW = rfr_pkg::tree_levels(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [NF-1:0] load_vec,
    input  logic          clr_en,
    input  logic [CW-1:0] clr_col,
    input  logic [RW-1:0] clr_row,
    output logic [NF-1:0] flags
);
    int clr_pos;

    // Linear bit position of the flag to clear.
    always_comb clr_pos = int'(clr_col) * ROWS + int'(clr_row);

    // Flag storage: reset empties it, load replaces it, clear drops one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (load_en) begin
            flags <= load_vec;
        end else if (clr_en) begin
            flags[clr_pos] <= 1'b0;
        end
    end

    // R5: no flag may appear except through a load.
    a_r5_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ((flags & ~$past(flags)) == '0));

    // R2: a load only ever lands on an empty bank.
    a_r2_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (flags == '0));
endmodule

// File: rtl/rfr_grid_encoder.sv
// Module rfr_grid_encoder
// Two-stage tree encoder for a column-by-row flag array. Each column has
// its own tree over its rows, and a top tree over the column-level "any"
// outputs picks the lowest active column. The row index of that column
// completes the address.
// Assumes: ROWS >= 2 and COLS >= 2.
module rfr_grid_encoder #(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    localparam int NF = ROWS * COLS,
    localparam int RW = rfr_pkg::tree_levels(ROWS),
    localparam int CW = rfr_pkg::tree_levels(COLS)
) (
    input  logic [NF-1:0] flags,
    output logic          any,
    output logic [CW-1:0] col_sel,
    output logic [RW-1:0] row_sel
);
    logic [COLS-1:0] col_any;
    logic [RW-1:0]   row_idx [COLS];

    generate
        // One row tree per column.
        for (genvar c = 0; c < COLS; c++) begin : g_col
            rfr_prio_tree #(.N(ROWS)) u_row_tree (
                .req (flags[c*ROWS +: ROWS]),
                .any (col_any[c]),
                .idx (row_idx[c])
            );
        end
    endgenerate

    // Column tree over the per-column summaries.
    rfr_prio_tree #(.N(COLS)) u_col_tree (
        .req (col_any),
        .any (any),
        .idx (col_sel)
    );

    // Row index of the winning column.
    always_comb row_sel = row_idx[col_sel];
endmodule

// File: rtl/rfr_addr_fifo.sv
// Module rfr_addr_fifo
// First-in first-out queue for reported addresses, with the head shown
// directly on rd_data.
// Assumes: DEPTH is a power of two, push is never raised while full, and
// pop while empty is ignored.
module rfr_addr_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 8,
    localparam int PW = rfr_pkg::tree_levels(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   count;
    logic          do_pop;

    // A pop counts only when something is stored.
    always_comb do_pop = pop & ~empty;

    // Storage write; no reset needed for the data words.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            if (push && !do_pop)      count <= count + 1'b1;
            else if (!push && do_pop) count <= count - 1'b1;
        end
    end

    // Status flags and head word.
    always_comb begin
        empty   = (count == '0);
        full    = (count == (PW+1)'(DEPTH));
        rd_data = mem[rd_ptr];
    end

    // R8: the queue is never written while full.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R9: a pop on an empty queue moves nothing.
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/rfr_road_readout.sv
// Module rfr_road_readout
// Top of the road flag readout encoder. It takes a flag array on load
// while idle, then reports one {column,row} address per clock in
// lowest-index-first order, clearing each reported flag and queueing its
// address. It pauses while the queue is full, and done marks an empty array.
// Assumes: ROWS, COLS, QDEPTH are powers of two, each at least 2.
module rfr_road_readout #(
    parameter int ROWS   = 8,
    parameter int COLS   = 4,
    parameter int QDEPTH = 8,
    localparam int NF = ROWS * COLS,
    localparam int RW = rfr_pkg::tree_levels(ROWS),
    localparam int CW = rfr_pkg::tree_levels(COLS),
    localparam int AW = CW + RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NF-1:0] load_flags,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          done,
    input  logic          q_pop,
    output logic [AW-1:0] q_data,
    output logic          q_empty,
    output logic          q_full
);
    logic [NF-1:0] flags;
    logic          any;
    logic [CW-1:0] col_sel;
    logic [RW-1:0] row_sel;
    logic          issue;
    logic          load_en;
    int            sel_pos;

    // Issue while flags remain and the queue has room; load only when idle.
    always_comb begin
        issue   = any & ~q_full;
        load_en = load & ~any;
        done    = ~any;
        sel_pos = int'(col_sel) * ROWS + int'(row_sel);
    end

    rfr_flag_bank #(.ROWS(ROWS), .COLS(COLS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_vec (load_flags),
        .clr_en   (issue),
        .clr_col  (col_sel),
        .clr_row  (row_sel),
        .flags    (flags)
    );

    rfr_grid_encoder #(.ROWS(ROWS), .COLS(COLS)) u_enc (
        .flags   (flags),
        .any     (any),
        .col_sel (col_sel),
        .row_sel (row_sel)
    );

    rfr_addr_fifo #(.W(AW), .DEPTH(QDEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (issue),
        .wr_data ({col_sel, row_sel}),
        .pop     (q_pop),
        .rd_data (q_data),
        .empty   (q_empty),
        .full    (q_full)
    );

    // Registered report of the address issued in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= issue;
            if (issue) out_addr <= {col_sel, row_sel};
        end
    end

    // R3: the issued flag is set and no lower-index flag is set.
    a_r3_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (flags[sel_pos] &&
                   ((flags & ((NF'(1) << sel_pos) - NF'(1))) == '0)));

    // R5: each issue removes exactly one flag.
    a_r5_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> ($countones(flags) == $past($countones(flags)) - 1));

    // R6: once empty, no further address is reported.
    a_r6_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !out_valid);

    // R8: a full queue blocks the next report.
    a_r8_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |=> !out_valid);
endmodule

// File: tb/rfr_road_readout_tb.sv
module rfr_road_readout_tb;
    localparam int CLK_P  = 10;
    localparam int ROWS   = 8;
    localparam int COLS   = 4;
    localparam int QDEPTH = 8;
    localparam int NF = ROWS * COLS;
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);
    localparam int AW = RW + CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [NF-1:0] load_flags = '0;
    logic          out_valid, done, q_empty, q_full;
    logic [AW-1:0] out_addr, q_data;
    logic          q_pop = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [AW-1:0] exp_a [0:63];
    int exp_n = 0;
    int mon_k = 0;
    int pop_k = 0;

    rfr_road_readout #(.ROWS(ROWS), .COLS(COLS), .QDEPTH(QDEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .load_flags(load_flags),
        .out_valid(out_valid), .out_addr(out_addr), .done(done),
        .q_pop(q_pop), .q_data(q_data), .q_empty(q_empty), .q_full(q_full)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Expected order: columns ascending, rows ascending inside each (R3).
    task automatic build_exp(input logic [NF-1:0] v);
        exp_n = 0;
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                if (v[c*ROWS + r]) begin
                    exp_a[exp_n] = {CW'(c), RW'(r)};
                    exp_n++;
                end
        mon_k = 0;
        pop_k = 0;
    endtask

    // Monitor: sampled after inputs settle, well before the next rising edge.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (out_valid) begin
                if (mon_k < exp_n) begin
                    chk(out_addr == exp_a[mon_k], "R3", int'(out_addr), int'(exp_a[mon_k]));
                    chk(done == (mon_k == exp_n - 1), "R6", int'(done), int'(mon_k == exp_n - 1));
                end else begin
                    chk(1'b0, "R5", mon_k + 1, exp_n);
                end
                mon_k++;
            end
            if (q_pop && !q_empty) begin
                if (pop_k < exp_n)
                    chk(q_data == exp_a[pop_k], "R7", int'(q_data), int'(exp_a[pop_k]));
                else
                    chk(1'b0, "R7", pop_k + 1, exp_n);
                pop_k++;
            end
        end
    end

    // Load one array with the queue drained each cycle; optionally pulse a
    // second load while busy, which must be ignored (R2).
    task automatic run_vec(input logic [NF-1:0] v, input bit busy_load, input logic [NF-1:0] bv);
        build_exp(v);
        q_pop = 1'b1;
        load = 1'b1;
        load_flags = v;
        @(negedge clk);
        load = 1'b0;
        chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
        chk(done == (exp_n == 0), "R2", int'(done), int'(exp_n == 0));
        for (int i = 0; i < exp_n; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R4", int'(out_valid), 1);
            if (busy_load && i == 0 && exp_n >= 4) begin
                load = 1'b1;
                load_flags = bv;
            end else begin
                load = 1'b0;
            end
        end
        @(negedge clk);
        load = 1'b0;
        chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
        chk(done == 1'b1, "R6", int'(done), 1);
        chk(mon_k == exp_n, "R5", mon_k, exp_n);
        for (int w = 0; w < 64 && !q_empty; w++) @(negedge clk);
        @(negedge clk);
        chk(pop_k == exp_n, "R7", pop_k, exp_n);
    endtask

    // Fill the queue with pops held off, then release it (R8).
    task automatic run_stall();
        logic [NF-1:0] v;
        v = '1;
        build_exp(v);
        q_pop = 1'b0;
        load = 1'b1;
        load_flags = v;
        @(negedge clk);
        load = 1'b0;
        for (int i = 0; i < QDEPTH; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R8", int'(out_valid), 1);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
            chk(q_full == 1'b1, "R8", int'(q_full), 1);
            chk(done == 1'b0, "R8", int'(done), 0);
        end
        q_pop = 1'b1;
        for (int w = 0; w < 400 && !(done && q_empty); w++) @(negedge clk);
        @(negedge clk);
        chk(mon_k == NF, "R8", mon_k, NF);
        chk(pop_k == NF, "R8", pop_k, NF);
    endtask

    initial begin : main
        logic [NF-1:0] v;
        logic [NF-1:0] bv;
        int            dens;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(done == 1'b1, "R1", int'(done), 1);
        chk(q_empty == 1'b1, "R1", int'(q_empty), 1);

        // R9: popping an empty queue changes nothing
        q_pop = 1'b1;
        repeat (3) @(negedge clk);
        chk(q_empty == 1'b1, "R9", int'(q_empty), 1);
        chk(q_full == 1'b0, "R9", int'(q_full), 0);
        chk(out_valid == 1'b0, "R9", int'(out_valid), 0);

        // Directed corners
        run_vec('0, 1'b0, '0);                        // R6: empty load
        run_vec(NF'(1), 1'b0, '0);                    // first position
        run_vec(NF'(1) << (NF - 1), 1'b0, '0);        // last position
        run_vec('1, 1'b1, NF'(1));                    // R2: busy load ignored
        v = '0;
        for (int c = 0; c < COLS; c++) v[c*ROWS + ROWS - 1] = 1'b1;
        run_vec(v, 1'b0, '0);                         // R3: one per column, top row
        run_vec({NF/2{2'b10}}, 1'b1, '1);             // R2: alternating, busy reload

        // R9: pop on empty between runs, then data stays correct
        repeat (4) @(negedge clk);
        chk(q_empty == 1'b1, "R9", int'(q_empty), 1);

        run_stall();

        // Random arrays of varying density
        for (int t = 0; t < 24; t++) begin
            dens = 1 + ($urandom() % 6);
            v = '0;
            for (int b = 0; b < NF; b++) v[b] = (($urandom() % 8) < dens);
            bv = '0;
            for (int b = 0; b < NF; b++) bv[b] = $urandom() % 2;
            run_vec(v, t[0], bv);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : watchdog
        #(CLK_P * 150000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule